// File: doc/BRIEF.md
# Access Width Sequencer for Memory and Port Buses

This block sits between an execution core and two external buses. The core hands it one access at a time: a memory or port target, a width of byte, word or long, a direction, a 16-bit address, up to 32 bits of write data and a port mode. The block splits the access into bus cycles. Memory traffic runs on a 16-bit big-endian bus with even word addresses. Port traffic runs as single bytes on an 8-bit bus, least significant byte first. Read results are gathered into one 32-bit value, and a one-cycle done pulse marks completion.

Each bus cycle holds its valid, address and data until the addressed side raises its ready. Only then does the next cycle start. When a port access carries a nonzero mode, no port bus cycle is issued. A read returns zero and a write is discarded.

Top module: `xws_seq`

## Requirements
- R1: `req_ready_o` is high only while the block is idle, and a request is taken only on a clock edge where both `req_valid_i` and `req_ready_o` are high. A request presented while the block is busy causes no bus cycle.
- R2: Word and long memory accesses drive the address with bit 0 cleared. Byte memory accesses drive the address unchanged, with `mem_byte_o` high.
- R3: A long memory access (width code 2) makes two word cycles. The first goes to the aligned address and carries bits 31:16. The second goes to the aligned address plus 2 and carries bits 15:0. Read data is assembled in the same way.
- R4: A port word access (width code 1) makes two byte cycles. Address A carries bits 7:0 and A+1 carries bits 15:8.
- R5: A port long access makes four byte cycles to A, A+1, A+2 and A+3, carrying bits 7:0, 15:8, 23:16 and 31:24 in that order.
- R6: A port request with a nonzero mode issues no port bus cycle. `done_o` rises in the cycle after acceptance and `rdata_o` reads zero.
- R7: A bus cycle keeps its valid, address, direction and write data steady until its ready is sampled high. No other cycle overlaps it.
- R8: `done_o` is high for exactly one clock, the clock after the final ready handshake, and `rdata_o` holds the result during it. Writes report zero.
- R9: Address steps wrap within 16 bits.
- R10: A memory byte access uses data bits 7:0 of the memory bus (width code 0), and a byte or word read is zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Idle; request can be taken |
| req_is_port_i | input | 1 | 1 = port target, 0 = memory |
| req_width_i | input | 2 | 0 byte, 1 word, 2 long (3 treated as long) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 32 | Write data, right-aligned |
| req_mode_i | input | 2 | Port mode; nonzero suppresses port cycles |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Assembled read result |
| mem_valid_o | output | 1 | Memory cycle active |
| mem_write_o | output | 1 | Memory cycle direction |
| mem_byte_o | output | 1 | Memory cycle is a byte access |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data |
| mem_ready_i | input | 1 | Memory cycle complete |
| io_valid_o | output | 1 | Port cycle active |
| io_write_o | output | 1 | Port cycle direction |
| io_addr_o | output | 16 | Port address |
| io_wdata_o | output | 8 | Port write data |
| io_rdata_i | input | 8 | Port read data |
| io_ready_i | input | 1 | Port cycle complete |

## Verification
The checker watches the handshake rules on every cycle. It checks that a stalled cycle stays stable, that the two buses are never active together and never active while idle or done, that a word or long memory address is even, that done lasts one cycle, and that a suppressed port request finishes at once without touching the port bus. The order of beats, the lane placement of each byte and word, the wrap at the top of the address space, the assembled read value and the dropping of requests made while busy all depend on the request contents. Only the bench scenarios, with their expected-beat scoreboard, can show these.

// File: rtl/xws_pkg.sv
package xws_pkg;
  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_WORD = 2'd1,
    W_LONG = 2'd2,
    W_RSVD = 2'd3
  } width_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;
endpackage

// File: rtl/xws_beat_plan.sv
module xws_beat_plan
  import xws_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MEM_DW = 16,
  parameter int IO_DW  = 8,
  localparam int LW    = 2 * MEM_DW,
  localparam int PBEAT = LW / IO_DW,
  localparam int BW    = $clog2(PBEAT)
) (
  input  logic              is_port_i,
  input  logic [1:0]        width_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LW-1:0]     wdata_i,
  input  logic [BW-1:0]     beat_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [MEM_DW-1:0] mem_wdata_o,
  output logic [IO_DW-1:0]  io_wdata_o,
  output logic              byte_o,
  output logic              last_o
);
  localparam int WBEAT = MEM_DW / IO_DW;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] step;
  logic [LW-1:0]     mem_sh;
  logic [LW-1:0]     io_sh;
  logic [BW-1:0]     last_idx;
  logic              is_long;

  assign is_long = (width_i == W_LONG) || (width_i == W_RSVD);
  assign byte_o  = (width_i == W_BYTE);

  always_comb begin
    if (is_port_i || byte_o) base = addr_i;
    else                     base = {addr_i[ADDR_W-1:1], 1'b0};
    step = '0;
    if (is_port_i) step[BW-1:0] = beat_i;
    else           step[BW:1]   = beat_i;
  end

  assign addr_o = base + step; // wraps in ADDR_W

  always_comb begin
    mem_sh = wdata_i;
    if (is_long && beat_i == '0) mem_sh = wdata_i >> MEM_DW;
    else if (byte_o)             mem_sh = {{(LW-IO_DW){1'b0}}, wdata_i[IO_DW-1:0]};
  end
  assign mem_wdata_o = mem_sh[MEM_DW-1:0];

  assign io_sh      = wdata_i >> (IO_DW * int'(beat_i));
  assign io_wdata_o = io_sh[IO_DW-1:0];

  always_comb begin
    last_idx = '0;
    if (is_port_i) begin
      if (is_long)                last_idx = BW'(PBEAT - 1);
      else if (width_i == W_WORD) last_idx = BW'(WBEAT - 1);
    end else if (is_long) begin
      last_idx = BW'(1);
    end
  end
  assign last_o = (beat_i == last_idx);
endmodule

// File: rtl/xws_rd_assemble.sv
module xws_rd_assemble
  import xws_pkg::*;
#(
  parameter int MEM_DW = 16,
  parameter int IO_DW  = 8,
  localparam int LW    = 2 * MEM_DW,
  localparam int PBEAT = LW / IO_DW,
  localparam int BW    = $clog2(PBEAT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              is_port_i,
  input  logic [1:0]        width_i,
  input  logic [BW-1:0]     beat_i,
  input  logic [MEM_DW-1:0] mem_rdata_i,
  input  logic [IO_DW-1:0]  io_rdata_i,
  output logic [LW-1:0]     acc_o
);
  logic [PBEAT-1:0] lane_hit;

  for (genvar g = 0; g < PBEAT; g++) begin : g_lane
    assign lane_hit[g] = (beat_i == BW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
    end else if (clr_i) begin
      acc_o <= '0;
    end else if (cap_i) begin
      if (is_port_i) begin
        for (int i = 0; i < PBEAT; i++)
          if (lane_hit[i]) acc_o[i*IO_DW +: IO_DW] <= io_rdata_i;
      end else begin
        case (width_i)
          W_BYTE: acc_o <= {{(LW-IO_DW){1'b0}}, mem_rdata_i[IO_DW-1:0]};
          W_WORD: acc_o <= {{MEM_DW{1'b0}}, mem_rdata_i};
          default: begin
            if (beat_i == '0) acc_o[LW-1:MEM_DW] <= mem_rdata_i;
            else              acc_o[MEM_DW-1:0]  <= mem_rdata_i;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/xws_seq.sv
module xws_seq
  import xws_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MEM_DW = 16,
  parameter int IO_DW  = 8,
  parameter int MODE_W = 2,
  localparam int LW    = 2 * MEM_DW,
  localparam int PBEAT = LW / IO_DW,
  localparam int BW    = $clog2(PBEAT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_is_port_i,
  input  logic [1:0]        req_width_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LW-1:0]     req_wdata_i,
  input  logic [MODE_W-1:0] req_mode_i,
  output logic              done_o,
  output logic [LW-1:0]     rdata_o,
  output logic              mem_valid_o,
  output logic              mem_write_o,
  output logic              mem_byte_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [MEM_DW-1:0] mem_wdata_o,
  input  logic [MEM_DW-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              io_valid_o,
  output logic              io_write_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic [IO_DW-1:0]  io_wdata_o,
  input  logic [IO_DW-1:0]  io_rdata_i,
  input  logic              io_ready_i
);
  seq_st_e           st_q;
  logic              port_q, write_q;
  logic [1:0]        width_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LW-1:0]     wdata_q;
  logic [BW-1:0]     beat_q;

  logic              accept, suppress, hs, last;
  logic [ADDR_W-1:0] beat_addr;
  logic              beat_byte;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign suppress    = req_is_port_i && (req_mode_i != '0);
  assign hs          = (st_q == ST_XFER) && (port_q ? io_ready_i : mem_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      port_q  <= 1'b0;
      write_q <= 1'b0;
      width_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      beat_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          port_q  <= req_is_port_i;
          write_q <= req_write_i;
          width_q <= req_width_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          beat_q  <= '0;
          st_q    <= suppress ? ST_DONE : ST_XFER;
        end
        ST_XFER: if (hs) begin
          if (last) st_q   <= ST_DONE;
          else      beat_q <= beat_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  xws_beat_plan #(.ADDR_W(ADDR_W), .MEM_DW(MEM_DW), .IO_DW(IO_DW)) u_plan (
    .is_port_i   (port_q),
    .width_i     (width_q),
    .addr_i      (addr_q),
    .wdata_i     (wdata_q),
    .beat_i      (beat_q),
    .addr_o      (beat_addr),
    .mem_wdata_o (mem_wdata_o),
    .io_wdata_o  (io_wdata_o),
    .byte_o      (beat_byte),
    .last_o      (last)
  );

  xws_rd_assemble #(.MEM_DW(MEM_DW), .IO_DW(IO_DW)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .cap_i       (hs && !write_q),
    .is_port_i   (port_q),
    .width_i     (width_q),
    .beat_i      (beat_q),
    .mem_rdata_i (mem_rdata_i),
    .io_rdata_i  (io_rdata_i),
    .acc_o       (rdata_o)
  );

  assign mem_valid_o = (st_q == ST_XFER) && !port_q;
  assign io_valid_o  = (st_q == ST_XFER) && port_q;
  assign mem_write_o = write_q;
  assign io_write_o  = write_q;
  assign mem_byte_o  = beat_byte;
  assign mem_addr_o  = beat_addr;
  assign io_addr_o   = beat_addr;
  assign done_o      = (st_q == ST_DONE);
endmodule

// File: rtl/xws_seq_chk.sv
module xws_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int MEM_DW = 16,
  parameter int IO_DW  = 8,
  parameter int MODE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_is_port_i,
  input logic [MODE_W-1:0] req_mode_i,
  input logic              done_o,
  input logic              mem_valid_o,
  input logic              mem_write_o,
  input logic              mem_byte_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [MEM_DW-1:0] mem_wdata_o,
  input logic              mem_ready_i,
  input logic              io_valid_o,
  input logic              io_write_o,
  input logic [ADDR_W-1:0] io_addr_o,
  input logic [IO_DW-1:0]  io_wdata_o,
  input logic              io_ready_i
);
  a_r7_one_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && io_valid_o));

  a_r7_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
      $stable(mem_wdata_o) && $stable(mem_write_o) && $stable(mem_byte_o));

  a_r7_io_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_o && !io_ready_i |=> io_valid_o && $stable(io_addr_o) &&
      $stable(io_wdata_o) && $stable(io_write_o));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_valid_o && !io_valid_o && !done_o);

  a_r2_even_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_byte_o |-> !mem_addr_o[0]);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);

  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_valid_o && !io_valid_o);

  a_r6_suppress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_is_port_i && (req_mode_i != '0)
      |=> done_o && !io_valid_o);
endmodule

bind xws_seq xws_seq_chk #(
  .ADDR_W(ADDR_W), .MEM_DW(MEM_DW), .IO_DW(IO_DW), .MODE_W(MODE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_is_port_i(req_is_port_i),
  .req_mode_i(req_mode_i), .done_o(done_o), .mem_valid_o(mem_valid_o),
  .mem_write_o(mem_write_o), .mem_byte_o(mem_byte_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .io_valid_o(io_valid_o),
  .io_write_o(io_write_o), .io_addr_o(io_addr_o), .io_wdata_o(io_wdata_o),
  .io_ready_i(io_ready_i)
);

// File: tb/xws_seq_test.sv
module xws_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_is_port_i = 1'b0;
  logic [1:0]  req_width_i = '0;
  logic        req_write_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [1:0]  req_mode_i = '0;
  logic        done_o;
  logic [31:0] rdata_o;
  logic        mem_valid_o, mem_write_o, mem_byte_o;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_ready_i = 1'b0;
  logic        io_valid_o, io_write_o;
  logic [15:0] io_addr_o;
  logic [7:0]  io_wdata_o, io_rdata_i;
  logic        io_ready_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    bit          port;
    bit          wr;
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } beat_t;
  beat_t exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xws_seq uut (.*);

  function automatic logic [15:0] mem_model(input logic [15:0] a);
    return a ^ 16'hA5C3;
  endfunction
  function automatic logic [7:0] io_model(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign mem_rdata_i = mem_model(mem_addr_o);
  assign io_rdata_i  = io_model(io_addr_o);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: drives ready with stalls, pops expected beats on each handshake
  always @(negedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      finish_run();
    end
    mem_ready_i = (cyc % 3) != 0;
    io_ready_i  = (cyc % 4) != 1;
    if (rst_ni && ((mem_valid_o && mem_ready_i) || (io_valid_o && io_ready_i))) begin
      if (exp_q.size() == 0) begin
        check(0, "R1 unexpected beat", {io_valid_o, 15'd0, mem_valid_o ? mem_addr_o : io_addr_o}, 0);
      end else begin
        beat_t e;
        logic [15:0] a, d;
        e = exp_q.pop_front();
        a = mem_valid_o ? mem_addr_o : io_addr_o;
        d = mem_valid_o ? mem_wdata_o : {8'h00, io_wdata_o};
        check(io_valid_o == e.port, {e.tag, " bus"}, 32'(io_valid_o), 32'(e.port));
        check(a == e.addr, {e.tag, " addr"}, 32'(a), 32'(e.addr));
        check((mem_valid_o ? mem_write_o : io_write_o) == e.wr, {e.tag, " dir"},
              32'(mem_valid_o ? mem_write_o : io_write_o), 32'(e.wr));
        if (e.wr) check(d == e.data, {e.tag, " wdata"}, 32'(d), 32'(e.data));
        if (mem_valid_o && !e.port) ; // byte flag checked in driver path
      end
    end
  end

  task automatic run_req(input bit port, input logic [1:0] w, input bit wr,
                         input logic [15:0] a, input logic [31:0] wd,
                         input logic [1:0] md, input bit poke, input string tag);
    logic [31:0] exp_rd = '0;
    int nb;
    bit done_seen = 0;
    if (port) begin
      nb = (md != 0) ? 0 : (w == 0) ? 1 : (w == 1) ? 2 : 4;
      for (int i = 0; i < nb; i++) begin
        beat_t b;
        b.port = 1; b.wr = wr; b.addr = a + 16'(i); b.tag = tag;
        b.data = {8'h00, wd[8*i +: 8]};
        if (!wr) exp_rd[8*i +: 8] = io_model(b.addr);
        exp_q.push_back(b);
      end
    end else begin
      logic [15:0] base;
      base = (w == 0) ? a : {a[15:1], 1'b0};
      nb = (w >= 2) ? 2 : 1;
      for (int i = 0; i < nb; i++) begin
        beat_t b;
        b.port = 0; b.wr = wr; b.addr = base + 16'(2*i); b.tag = tag;
        if (w >= 2)      b.data = (i == 0) ? wd[31:16] : wd[15:0];
        else if (w == 1) b.data = wd[15:0];
        else             b.data = {8'h00, wd[7:0]};
        if (!wr) begin
          if (w >= 2)      exp_rd[31-16*i -: 16] = mem_model(b.addr);
          else if (w == 1) exp_rd = {16'h0, mem_model(b.addr)};
          else             exp_rd = {24'h0, mem_model(b.addr)[7:0]};
        end
        exp_q.push_back(b);
      end
    end
    @(negedge clk_i);
    check(req_ready_o == 1'b1, {tag, " R1 idle before req"}, 32'(req_ready_o), 1);
    req_is_port_i = port; req_width_i = w; req_write_i = wr;
    req_addr_i = a; req_wdata_i = wd; req_mode_i = md; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int t = 0; t < 200 && !done_seen; t++) begin
      if (done_o) begin
        done_seen = 1;
      end else begin
        if (!port && mem_valid_o)
          check(mem_byte_o == (w == 0), {tag, " R10 byte flag"}, 32'(mem_byte_o), 32'(w == 0));
        if (poke && t == 0) begin
          check(req_ready_o == 1'b0, "R1 busy not ready", 32'(req_ready_o), 0);
          req_addr_i = 16'h7770; req_is_port_i = 1'b1; req_valid_i = 1'b1;
        end else begin
          req_valid_i = 1'b0;
        end
        @(negedge clk_i);
      end
    end
    req_valid_i = 1'b0;
    check(done_seen, {tag, " R8 done seen"}, 32'(done_seen), 1);
    check(rdata_o == exp_rd, {tag, " R8 rdata"}, rdata_o, exp_rd);
    check(exp_q.size() == 0, {tag, " R8 all beats before done"}, 32'(exp_q.size()), 0);
    exp_q.delete();
    @(negedge clk_i);
    check(!done_o && req_ready_o, {tag, " R8 done one cycle"}, {done_o, req_ready_o}, 32'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(req_ready_o && !done_o && !mem_valid_o && !io_valid_o, "R1 reset state",
          {req_ready_o, done_o, mem_valid_o, io_valid_o}, 32'b1000);
    rst_ni = 1'b1;
    run_req(0, 2'd1, 0, 16'h1235, 0, 0, 0, "R2 mem word read odd");
    run_req(0, 2'd0, 0, 16'h1235, 0, 0, 0, "R10 mem byte read");
    run_req(0, 2'd0, 1, 16'h4443, 32'h0000_00A7, 0, 0, "R2 mem byte write");
    run_req(0, 2'd2, 0, 16'h2001, 0, 0, 0, "R3 mem long read");
    run_req(0, 2'd2, 1, 16'h3000, 32'hDEAD_BEEF, 0, 0, "R3 mem long write");
    run_req(1, 2'd1, 0, 16'h0040, 0, 0, 0, "R4 port word read");
    run_req(1, 2'd1, 1, 16'h0051, 32'h0000_C3D4, 0, 0, "R4 port word write");
    run_req(1, 2'd2, 1, 16'h0080, 32'h1122_3344, 0, 0, "R5 port long write");
    run_req(1, 2'd2, 0, 16'h0100, 0, 0, 0, "R5 port long read");
    run_req(1, 2'd2, 0, 16'hFFFE, 0, 0, 0, "R9 port long wrap");
    run_req(0, 2'd2, 0, 16'hFFFF, 0, 0, 0, "R9 mem long wrap");
    run_req(1, 2'd1, 0, 16'h0040, 0, 2'd1, 0, "R6 port read suppressed");
    run_req(1, 2'd2, 1, 16'h0080, 32'hFFFF_FFFF, 2'd3, 0, "R6 port write suppressed");
    run_req(0, 2'd2, 0, 16'h5554, 0, 0, 1, "R1 busy request ignored");
    run_req(1, 2'd0, 0, 16'h0033, 0, 0, 0, "R7 port byte after stall");
    finish_run();
  end
endmodule